// File: doc/BRIEF.md
# Power-Management Event Block with System Control Interrupt

This block holds the event side of a power-management register set. Its three 16-bit registers are event status, event enable and control, and they sit in a 64-byte I/O window. Configuration inputs move the window in I/O space and switch it on or off. Four one-cycle event pulses latch sticky status bits: timer overflow, global lock release, power button and real-time-clock alarm. Software clears these bits by writing ones to them.

The block drives a level-sensitive system control interrupt while any of the four status bits is set with its matching enable bit. It also drives a timer-arm flag that tells the external free-running timer to schedule its next overflow event. The flag is high only while the timer event is enabled and has not yet been latched. The timer counter itself lives outside this block.

Top module: `pm_event_ctl`

## Requirements
- R1: After synchronous reset, status, enable and control are all zero, the window is closed, and `sci` and `tmr_arm` are low.
- R2: An event pulse sets its status bit on the next clock edge. The bit positions are timer 0, global lock 5, power button 8 and RTC 10. All other status bits always read 0.
- R3: Writing to status (window offset 0x00) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a clear of the same bit land in the same cycle, the bit ends up set.
- R5: `sci` is high exactly while at least one of the four status bits and its enable bit (same bit position, enable at offset 0x02) are both 1. It follows the registers with no extra delay.
- R6: `tmr_arm` is high exactly while enable bit 0 is 1 and status bit 0 is 0.
- R7: Enable (offset 0x02) and control (offset 0x04) store and return all 16 written bits. A write takes effect at the next clock edge.
- R8: Offsets inside the window other than 0x00, 0x02 and 0x04 read as zero, and writes to them change no register.
- R9: The window base is `cfg_base[15:6]`, so the window is 64-byte aligned. The low six and the upper sixteen bits of `cfg_base` are ignored. Addresses outside the window read zero and writes to them are ignored.
- R10: The window opens only while `cfg_ctl[0]` is 1. The configuration is registered, so a change takes effect one clock edge later.
- R11: `io_rdata` is zero whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Configuration dword holding the window base |
| cfg_ctl | input | 8 | Configuration byte, bit 0 opens the window |
| io_addr | input | 16 | I/O address of a 16-bit access (bit 0 ignored) |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational from the address |
| ev_tmr | input | 1 | Timer overflow event pulse |
| ev_glock | input | 1 | Global lock event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| sci | output | 1 | Level system control interrupt |
| tmr_arm | output | 1 | Request to arm the timer overflow event |

## Verification
Register writes and event pulses take effect at the first rising edge after they are driven. `sci` and `tmr_arm` follow that edge combinationally, so their new value is due in the same cycle. Read data is combinational, so a read is driven on a falling edge and sampled two nanoseconds later, well before the next rising edge. Configuration changes take one edge to reach the decoder. The bench therefore reads once in the cycle of the change, expecting the old window, and once after the next edge, expecting the new one.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int DATA_W   = 16;
    localparam int BIT_TMR  = 0;
    localparam int BIT_GLK  = 5;
    localparam int BIT_PWR  = 8;
    localparam int BIT_RTC  = 10;

    localparam logic [DATA_W-1:0] STS_MASK =
        (DATA_W'(1) << BIT_TMR) | (DATA_W'(1) << BIT_GLK) |
        (DATA_W'(1) << BIT_PWR) | (DATA_W'(1) << BIT_RTC);

    typedef enum logic [1:0] {
        SEL_STS  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } pm_sel_e;

    typedef struct packed {
        logic    hit;
        pm_sel_e sel;
    } pm_dec_t;

    typedef struct packed {
        logic rtc;
        logic pwr;
        logic glk;
        logic tmr;
    } pm_evt_t;

    function automatic pm_sel_e word_select(input logic [7:0] wix);
        case (wix)
            8'd0:    return SEL_STS;
            8'd1:    return SEL_EN;
            8'd2:    return SEL_CTL;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] evt_bits(input pm_evt_t e);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_TMR] = e.tmr;
        v[BIT_GLK] = e.glk;
        v[BIT_PWR] = e.pwr;
        v[BIT_RTC] = e.rtc;
        return v;
    endfunction

endpackage

// File: rtl/pm_window_decode.sv
module pm_window_decode
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_base,
    input  logic [7:0]        cfg_ctl,
    input  logic [ADDR_W-1:0] io_addr,
    output pm_dec_t           dec
);
    localparam int BASE_W = ADDR_W - WIN_BITS;

    logic [BASE_W-1:0] base_q;
    logic              open_q;
    logic [7:0]        wix;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            open_q <= 1'b0;
        end else begin
            base_q <= cfg_base[ADDR_W-1:WIN_BITS];
            open_q <= cfg_ctl[0];
        end
    end

    always_comb begin
        wix     = 8'(io_addr[WIN_BITS-1:1]);
        dec.hit = open_q && (io_addr[ADDR_W-1:WIN_BITS] == base_q);
        dec.sel = word_select(wix);
    end

    logic unused_cfg;
    assign unused_cfg = ^{cfg_base[31:ADDR_W], cfg_base[WIN_BITS-1:0],
                          cfg_ctl[7:1], io_addr[0]};

    // R10: a closed configuration in the previous cycle gives no hit now
    a_r10_closed_no_hit: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_ctl[0]) |-> !dec.hit);

endmodule

// File: rtl/pm_status_reg.sv
module pm_status_reg
    import pm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pm_evt_t           evt,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] sts_q
);
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] sts_d;

    always_comb begin
        clr_mask = clr_we ? clr_data : '0;
        sts_d    = ((sts_q & ~clr_mask) | evt_bits(evt)) & STS_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_d;
    end

    // R4: a pulse always leaves its bit set, even against a clear
    a_r4_pulse_wins: assert property (@(posedge clk) disable iff (rst)
        evt.tmr |=> sts_q[BIT_TMR]);
    // R3: a clear without a competing pulse empties the bit
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_data[BIT_PWR] && !evt.pwr) |=> !sts_q[BIT_PWR]);
    // R2: without pulses or writes the status holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && evt == '0) |=> $stable(sts_q));

endmodule

// File: rtl/pm_enable_ctl.sv
module pm_enable_ctl
    import pm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_en,
    input  logic              we_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] ctl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (we_en)  en_q  <= wdata;
            if (we_ctl) ctl_q <= wdata;
        end
    end

    // R7: a write lands in full at the next edge
    a_r7_en_write: assert property (@(posedge clk) disable iff (rst)
        we_en |=> (en_q == $past(wdata)));
    a_r7_ctl_write: assert property (@(posedge clk) disable iff (rst)
        we_ctl |=> (ctl_q == $past(wdata)));

endmodule

// File: rtl/pm_event_ctl.sv
module pm_event_ctl
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_base,
    input  logic [7:0]        cfg_ctl,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic              ev_tmr,
    input  logic              ev_glock,
    input  logic              ev_pwrbtn,
    input  logic              ev_rtc,
    output logic              sci,
    output logic              tmr_arm
);
    pm_dec_t           dec;
    pm_evt_t           evt;
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ctl_q;
    logic              wr_sts;
    logic              wr_en;
    logic              wr_ctl;

    pm_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
        .io_addr(io_addr), .dec(dec)
    );

    always_comb begin
        evt.tmr = ev_tmr;
        evt.glk = ev_glock;
        evt.pwr = ev_pwrbtn;
        evt.rtc = ev_rtc;
        wr_sts  = io_wr && dec.hit && (dec.sel == SEL_STS);
        wr_en   = io_wr && dec.hit && (dec.sel == SEL_EN);
        wr_ctl  = io_wr && dec.hit && (dec.sel == SEL_CTL);
    end

    pm_status_reg u_sts (
        .clk(clk), .rst(rst), .evt(evt), .clr_we(wr_sts),
        .clr_data(io_wdata), .sts_q(sts_q)
    );

    pm_enable_ctl u_enc (
        .clk(clk), .rst(rst), .we_en(wr_en), .we_ctl(wr_ctl),
        .wdata(io_wdata), .en_q(en_q), .ctl_q(ctl_q)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd && dec.hit) begin
            case (dec.sel)
                SEL_STS: io_rdata = sts_q;
                SEL_EN:  io_rdata = en_q;
                SEL_CTL: io_rdata = ctl_q;
                default: io_rdata = '0;
            endcase
        end
    end

    always_comb begin
        sci     = |(sts_q & en_q & STS_MASK);
        tmr_arm = en_q[BIT_TMR] && !sts_q[BIT_TMR];
    end

    // R11: no read strobe, no data
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0));
    // R5: an enabled RTC pulse raises the interrupt one edge later
    a_r5_rtc_raises: assert property (@(posedge clk) disable iff (rst)
        (ev_rtc && en_q[BIT_RTC] && !io_wr) |=> sci);
    // R6: a freshly latched timer event drops the arm request
    a_r6_arm_drops: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[BIT_TMR]) |-> !tmr_arm);

endmodule

// File: tb/pm_event_ctl_test.sv
module pm_event_ctl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_base;
    logic [7:0]  cfg_ctl;
    logic [15:0] io_addr;
    logic        io_wr, io_rd;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata;
    logic        ev_tmr, ev_glock, ev_pwrbtn, ev_rtc;
    logic        sci, tmr_arm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [15:0] BASE = 16'hB000;

    always #10 clk = ~clk;

    pm_event_ctl uut (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ev_tmr(ev_tmr), .ev_glock(ev_glock),
        .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .sci(sci), .tmr_arm(tmr_arm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        io_addr = a; io_rd = 1'b1;
        #2;
        chk(tag, {16'h0, io_rdata}, {16'h0, exp});
        io_rd = 1'b0;
    endtask

    task automatic pulse(input logic t, input logic g, input logic p, input logic r);
        @(negedge clk);
        ev_tmr = t; ev_glock = g; ev_pwrbtn = p; ev_rtc = r;
        @(posedge clk);
        @(negedge clk);
        ev_tmr = 0; ev_glock = 0; ev_pwrbtn = 0; ev_rtc = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 sci", {31'h0, sci}, 0);
        chk("R1 tmr_arm", {31'h0, tmr_arm}, 0);
        rd_chk("R1 window closed", BASE, 16'h0);
    endtask

    task automatic t_open;
        @(negedge clk);
        cfg_base = 32'hABCD_B03F; cfg_ctl = 8'hFF;
        rd_chk("R10 open not yet active", BASE + 16'h4, 16'h0);
        @(posedge clk); @(negedge clk);
        rd_chk("R1 status zero", BASE, 16'h0);
        rd_chk("R1 enable zero", BASE + 16'h2, 16'h0);
        rd_chk("R1 control zero", BASE + 16'h4, 16'h0);
    endtask

    task automatic t_regs;
        wr(BASE + 16'h2, 16'hA5C3);
        rd_chk("R7 enable readback", BASE + 16'h2, 16'hA5C3);
        wr(BASE + 16'h4, 16'h1234);
        rd_chk("R7 control readback", BASE + 16'h4, 16'h1234);
        wr(BASE + 16'h2, 16'h0000);
        rd_chk("R7 enable cleared", BASE + 16'h2, 16'h0);
        io_addr = BASE + 16'h4; io_rd = 1'b0; #2;
        chk("R11 rdata zero without rd", {16'h0, io_rdata}, 0);
    endtask

    task automatic t_unused;
        wr(BASE + 16'h6, 16'hFFFF);
        wr(BASE + 16'h3E, 16'hFFFF);
        rd_chk("R8 offset 06 reads zero", BASE + 16'h6, 16'h0);
        rd_chk("R8 offset 3E reads zero", BASE + 16'h3E, 16'h0);
        rd_chk("R8 enable untouched", BASE + 16'h2, 16'h0);
        rd_chk("R8 control untouched", BASE + 16'h4, 16'h1234);
    endtask

    task automatic t_outside;
        wr(BASE + 16'h40 + 16'h4, 16'hFFFF);
        wr(BASE - 16'h40 + 16'h2, 16'hFFFF);
        rd_chk("R9 next window reads zero", BASE + 16'h44, 16'h0);
        rd_chk("R9 control untouched", BASE + 16'h4, 16'h1234);
        rd_chk("R9 enable untouched", BASE + 16'h2, 16'h0);
    endtask

    task automatic t_events;
        pulse(1, 1, 1, 1);
        rd_chk("R2 all four bits", BASE, 16'h0521);
        wr(BASE, 16'h0000);
        rd_chk("R3 zero write keeps", BASE, 16'h0521);
        wr(BASE, 16'h0020);
        rd_chk("R3 clear glock only", BASE, 16'h0501);
        wr(BASE, 16'hFFFF);
        rd_chk("R3 clear all", BASE, 16'h0);
        pulse(0, 0, 1, 0);
        rd_chk("R2 power button bit 8", BASE, 16'h0100);
        wr(BASE, 16'h0100);
    endtask

    task automatic t_pulse_wins;
        @(negedge clk);
        ev_tmr = 1; io_addr = BASE; io_wdata = 16'h0001; io_wr = 1;
        @(posedge clk); @(negedge clk);
        ev_tmr = 0; io_wr = 0;
        rd_chk("R4 pulse beats clear", BASE, 16'h0001);
        wr(BASE, 16'h0001);
        rd_chk("R4 later clear works", BASE, 16'h0000);
    endtask

    task automatic t_sci;
        wr(BASE + 16'h2, 16'h0100);
        chk("R5 enabled but no status", {31'h0, sci}, 0);
        @(negedge clk); ev_pwrbtn = 1; #2;
        chk("R5 not before edge", {31'h0, sci}, 0);
        @(posedge clk); @(negedge clk); ev_pwrbtn = 0;
        chk("R5 power button sci", {31'h0, sci}, 1);
        wr(BASE, 16'h0100);
        chk("R5 cleared drops sci", {31'h0, sci}, 0);
        pulse(0, 0, 0, 1);
        chk("R5 rtc not enabled", {31'h0, sci}, 0);
        wr(BASE + 16'h2, 16'h0400);
        chk("R5 enabling rtc raises", {31'h0, sci}, 1);
        wr(BASE + 16'h2, 16'hFBDE);
        chk("R5 other enables ignored", {31'h0, sci}, 0);
        wr(BASE, 16'hFFFF);
        pulse(0, 1, 0, 0);
        wr(BASE + 16'h2, 16'h0020);
        chk("R5 global lock sci", {31'h0, sci}, 1);
        wr(BASE, 16'hFFFF);
        chk("R5 global lock cleared", {31'h0, sci}, 0);
    endtask

    task automatic t_arm;
        wr(BASE + 16'h2, 16'h0000);
        chk("R6 disabled no arm", {31'h0, tmr_arm}, 0);
        wr(BASE + 16'h2, 16'h0001);
        chk("R6 enabled arms", {31'h0, tmr_arm}, 1);
        chk("R5 timer enabled no status", {31'h0, sci}, 0);
        pulse(1, 0, 0, 0);
        chk("R6 status disarms", {31'h0, tmr_arm}, 0);
        chk("R5 timer sci", {31'h0, sci}, 1);
        wr(BASE, 16'h0001);
        chk("R6 clear rearms", {31'h0, tmr_arm}, 1);
    endtask

    task automatic t_close;
        @(negedge clk);
        cfg_ctl = 8'hFE;
        rd_chk("R10 close not yet active", BASE + 16'h4, 16'h1234);
        @(posedge clk); @(negedge clk);
        rd_chk("R10 closed reads zero", BASE + 16'h4, 16'h0);
        wr(BASE + 16'h4, 16'h5555);
        @(negedge clk);
        cfg_ctl = 8'h01;
        @(posedge clk); @(negedge clk);
        rd_chk("R10 closed write ignored", BASE + 16'h4, 16'h1234);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1; cfg_base = 32'h0; cfg_ctl = 8'h0;
        io_addr = 16'h0; io_wr = 0; io_rd = 0; io_wdata = 16'h0;
        ev_tmr = 0; ev_glock = 0; ev_pwrbtn = 0; ev_rtc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_open;
        t_regs;
        t_unused;
        t_outside;
        t_events;
        t_pulse_wins;
        t_sci;
        t_arm;
        t_close;
        summary;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary;
    end
endmodule